// File: doc/BRIEF.md
# Stochastic Bit-Stream Arithmetic Unit

This block performs one stochastic-computing operation per stream cycle on single-bit lanes. A number in [0,1] is carried as the share of 1s in a bit stream, so the stream 10101 stands for 3/5. Operand lanes `a_bit` and `b_bit` carry the operands. A third lane, `s_bit`, carries either a helper stream or a select stream. For each accepted input bit the unit returns one result bit, registered, together with a valid flag.

A stream starts with a one-cycle `start` pulse. That pulse latches the 3-bit operation code and clears the state element used by division. Bits that arrive with `in_valid` are then processed under that code until the next `start`. Several operations give correct results only when the streams meet certain conditions, and the upstream generator is responsible for them:
- Multiply and scaled add need uncorrelated inputs.
- The helper stream for scaled add must carry probability 0.5.
- Subtract, minimum, maximum and divide need correlated inputs.
- Divide also needs X ≤ Y.
- Approximate add is accurate only when both inputs are in [0, 0.5].

The control state machine has two states:
- `ST_IDLE` is the state after reset. Input bits are ignored here. The transition *begin* (`start`=1) moves to `ST_STREAM`.
- `ST_STREAM` processes bits. The transition *restart* (`start`=1) stays in `ST_STREAM` and relatches the code. The transition *continue* (`start`=0) stays in `ST_STREAM` with no other effect.

Top module: `sc_stream_alu`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` and `out_bit` are 0 until a bit is accepted.
- R2: `op_in` is sampled only in a cycle with `start`=1. Changes to `op_in` in other cycles have no effect on results.
- R3: A bit is accepted when `in_valid`=1, `start`=0 and a stream has been started since reset. `out_valid` is 1 in the cycle after an accepted bit and 0 after any other cycle. `in_valid` in the `start` cycle or before the first `start` is ignored.
- R4: `out_bit` is 0 whenever `out_valid` is 0.
- R5: Code 0 (multiply) and code 5 (minimum) give `a_bit` AND `b_bit`.
- R6: Code 1 (scaled add) gives the majority of `a_bit`, `b_bit` and `s_bit`.
- R7: Code 2 (approximate add) and code 6 (maximum) give `a_bit` OR `b_bit`.
- R8: Code 3 (absolute subtract) gives `a_bit` XOR `b_bit`.
- R9: Code 4 (divide) uses X on `a_bit` and Y on `b_bit`. When Y=1 the result is X and the stored bit takes X. When Y=0 the result is the stored bit, which is left unchanged.
- R10: The stored divide bit is cleared to 0 by every `start` pulse.
- R11: Code 7 (select) gives `a_bit` when `s_bit`=1 and `b_bit` when `s_bit`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a stream: latches the code and clears the divide state |
| op_in | input | 3 | Operation code |
| in_valid | input | 1 | Input bits are valid this cycle |
| a_bit | input | 1 | Stream A (X for divide, foreground for select) |
| b_bit | input | 1 | Stream B (Y for divide, background for select) |
| s_bit | input | 1 | Helper or select stream |
| out_bit | output | 1 | Result bit |
| out_valid | output | 1 | Result bit is valid |

## Verification
Every result is due exactly one clock after the edge that accepts its input bit, because one output register sits between the inputs and the ports. The divide state element adds no further latency: a Y=0 bit returns the value stored at an earlier edge. The bench changes inputs on the falling edge and reads the outputs 1 ns after the next rising edge, so each reading belongs to exactly one input bit. For divide chains, the expected stored bit is carried forward in the order of the sequence.

// File: rtl/sc_alu_pkg.sv
package sc_alu_pkg;
    localparam int OP_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_MUL  = 3'd0,
        OP_SADD = 3'd1,
        OP_AADD = 3'd2,
        OP_ASUB = 3'd3,
        OP_DIV  = 3'd4,
        OP_MIN  = 3'd5,
        OP_MAX  = 3'd6,
        OP_SEL  = 3'd7
    } sc_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_STREAM = 1'b1
    } sc_state_e;
endpackage

// File: rtl/sc_op_ctrl.sv
module sc_op_ctrl
    import sc_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] op_in,
    input  logic            in_valid,
    output sc_op_e          op_q,
    output sc_state_e       state_q,
    output logic            accept
);
    sc_state_e state_d;

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   state_d = start ? ST_STREAM : ST_IDLE;   // begin
            ST_STREAM: state_d = ST_STREAM;                     // restart / continue
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // operation register, loaded on start only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     op_q <= OP_MUL;
        else if (start) op_q <= sc_op_e'(op_in);
    end

    // accepted-bit qualifier
    always_comb begin
        accept = in_valid && !start && (state_q == ST_STREAM);
    end

    a_r2_op_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(op_q));

    a_r2_op_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (op_q == $past(op_in)));

    a_r3_idle_until_start: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/sc_cordiv_cell.sv
module sc_cordiv_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    input  logic x_bit,
    input  logic y_bit,
    output logic z_bit,
    output logic held_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               held_q <= 1'b0;
        else if (clear)           held_q <= 1'b0;
        else if (enable && y_bit) held_q <= x_bit;
    end

    always_comb begin
        z_bit = y_bit ? x_bit : held_q;
    end

    a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !held_q);

    a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && y_bit && !clear) |=> (held_q == $past(x_bit)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !(enable && y_bit)) |=> $stable(held_q));
endmodule

// File: rtl/sc_bit_logic.sv
module sc_bit_logic
    import sc_alu_pkg::*;
(
    input  sc_op_e op,
    input  logic   a_bit,
    input  logic   b_bit,
    input  logic   s_bit,
    input  logic   div_bit,
    output logic   y_bit
);
    always_comb begin
        y_bit = 1'b0;
        unique case (op)
            OP_MUL,
            OP_MIN:  y_bit = a_bit & b_bit;
            OP_SADD: y_bit = (a_bit & b_bit) | (a_bit & s_bit) | (b_bit & s_bit);
            OP_AADD,
            OP_MAX:  y_bit = a_bit | b_bit;
            OP_ASUB: y_bit = a_bit ^ b_bit;
            OP_DIV:  y_bit = div_bit;
            OP_SEL:  y_bit = s_bit ? a_bit : b_bit;
            default: y_bit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sc_stream_alu.sv
module sc_stream_alu
    import sc_alu_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OP_W-1:0] op_in,
    input  logic            in_valid,
    input  logic            a_bit,
    input  logic            b_bit,
    input  logic            s_bit,
    output logic            out_bit,
    output logic            out_valid
);
    sc_op_e    op_q;
    sc_state_e state_q;
    logic      accept;
    logic      div_z;
    logic      div_held;
    logic      y_bit;

    sc_op_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op_in    (op_in),
        .in_valid (in_valid),
        .op_q     (op_q),
        .state_q  (state_q),
        .accept   (accept)
    );

    sc_cordiv_cell u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .enable (accept && (op_q == OP_DIV)),
        .x_bit  (a_bit),
        .y_bit  (b_bit),
        .z_bit  (div_z),
        .held_q (div_held)
    );

    sc_bit_logic u_logic (
        .op      (op_q),
        .a_bit   (a_bit),
        .b_bit   (b_bit),
        .s_bit   (s_bit),
        .div_bit (div_z),
        .y_bit   (y_bit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
        end else begin
            out_valid <= accept;
            out_bit   <= accept ? y_bit : 1'b0;
        end
    end

    a_r3_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !start && state_q == ST_STREAM) |=> out_valid);

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !start && state_q == ST_STREAM) |=> !out_valid);

    a_r4_quiet_low: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_bit);

    a_r11_select: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_q == OP_SEL) |=> (out_bit == ($past(s_bit) ? $past(a_bit) : $past(b_bit))));

    a_r9_div_hold_out: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_q == OP_DIV && !b_bit) |=> (out_bit == $past(div_held)));
endmodule

// File: tb/test_sc_stream_alu.sv
`timescale 1ns/1ps
module test_sc_stream_alu;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       start;
    logic [2:0] op_in;
    logic       in_valid;
    logic       a_bit;
    logic       b_bit;
    logic       s_bit;
    logic       out_bit;
    logic       out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sc_stream_alu i_sc_stream_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .op_in     (op_in),
        .in_valid  (in_valid),
        .a_bit     (a_bit),
        .b_bit     (b_bit),
        .s_bit     (s_bit),
        .out_bit   (out_bit),
        .out_valid (out_valid)
    );

    // vector: [6:4] code, [3] a, [2] b, [1] s, [0] expected result
    localparam int NV = 25;
    localparam logic [6:0] VEC [NV] = '{
        7'b000_1_1_0_1, 7'b000_1_0_0_0, 7'b000_0_1_1_0,
        7'b001_1_1_0_1, 7'b001_1_0_0_0, 7'b001_1_0_1_1, 7'b001_0_0_1_0, 7'b001_0_1_1_1,
        7'b010_0_0_0_0, 7'b010_1_0_0_1, 7'b010_0_1_0_1,
        7'b011_1_1_0_0, 7'b011_1_0_0_1, 7'b011_0_1_0_1, 7'b011_0_0_1_0,
        7'b101_1_1_0_1, 7'b101_0_1_0_0,
        7'b110_0_0_0_0, 7'b110_0_1_0_1,
        7'b111_1_0_1_1, 7'b111_1_0_0_0, 7'b111_0_1_0_1, 7'b111_0_1_1_0,
        7'b100_1_1_0_1, 7'b100_1_0_0_0
    };

    function automatic string tag_of(logic [2:0] op);
        case (op)
            3'd0, 3'd5: return "R5";
            3'd1:       return "R6";
            3'd2, 3'd6: return "R7";
            3'd3:       return "R8";
            3'd4:       return "R9";
            default:    return "R11";
        endcase
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic cyc(logic st, logic [2:0] op, logic v, logic a, logic b, logic s);
        @(negedge clk);
        start = st; op_in = op; in_valid = v; a_bit = a; b_bit = b; s_bit = s;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #100000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int ones;
        logic held;
        rst_n = 1'b0; start = 0; op_in = 0; in_valid = 0; a_bit = 0; b_bit = 0; s_bit = 0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 valid in reset", out_valid, 1'b0);
        chk("R1 bit in reset", out_bit, 1'b0);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        chk("R1 valid after reset", out_valid, 1'b0);

        // R3: bits before the first start are ignored
        cyc(0, 3'd2, 1, 1, 1, 1);
        chk("R3 idle ignore", out_valid, 1'b0);
        chk("R4 idle bit low", out_bit, 1'b0);

        // R3: valid bit during start cycle is ignored
        cyc(1, 3'd2, 1, 1, 1, 0);
        chk("R3 start cycle ignore", out_valid, 1'b0);
        cyc(0, 3'd2, 1, 1, 0, 0);
        chk("R3 accepted valid", out_valid, 1'b1);
        chk("R7 first bit", out_bit, 1'b1);
        cyc(0, 3'd2, 0, 1, 1, 0);
        chk("R3 bubble valid", out_valid, 1'b0);
        chk("R4 bubble bit", out_bit, 1'b0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            cyc(1, VEC[i][6:4], 0, 0, 0, 0);
            cyc(0, VEC[i][6:4], 1, VEC[i][3], VEC[i][2], VEC[i][1]);
            chk({tag_of(VEC[i][6:4]), " table valid"}, out_valid, 1'b1);
            chk({tag_of(VEC[i][6:4]), " table bit"}, out_bit, VEC[i][0]);
        end

        // R2: code held between starts
        cyc(1, 3'd0, 0, 0, 0, 0);
        cyc(0, 3'd2, 1, 1, 0, 0);
        chk("R2 code held (AND not OR)", out_bit, 1'b0);
        cyc(0, 3'd6, 1, 0, 1, 0);
        chk("R2 code held again", out_bit, 1'b0);

        // R9/R10: divide chain
        cyc(1, 3'd4, 0, 0, 0, 0);
        held = 1'b0;
        cyc(0, 3'd4, 1, 1, 1, 0); held = 1'b1;
        chk("R9 y1 passes x", out_bit, 1'b1);
        cyc(0, 3'd4, 1, 0, 0, 0);
        chk("R9 y0 stored", out_bit, held);
        cyc(0, 3'd4, 0, 0, 1, 0);
        cyc(0, 3'd4, 1, 0, 0, 0);
        chk("R9 no capture on idle cycle", out_bit, held);
        cyc(0, 3'd4, 1, 0, 1, 0); held = 1'b0;
        chk("R9 y1 x0", out_bit, 1'b0);
        cyc(0, 3'd4, 1, 1, 0, 0);
        chk("R9 stored zero", out_bit, held);
        cyc(0, 3'd4, 1, 1, 1, 0); held = 1'b1;
        chk("R9 recapture", out_bit, 1'b1);
        cyc(1, 3'd4, 0, 0, 0, 0);
        cyc(0, 3'd4, 1, 1, 0, 0);
        chk("R10 cleared by start", out_bit, 1'b0);

        // R5: multiply stream 1010.. x 1100.. -> 4 ones in 16
        cyc(1, 3'd0, 0, 0, 0, 0);
        ones = 0;
        for (int k = 0; k < 16; k++) begin
            cyc(0, 3'd0, 1, (k % 2) == 0, (k % 4) < 2, 0);
            if (out_valid && out_bit) ones++;
        end
        checks++;
        if (ones != 4) begin
            fails++;
            $display("FAIL R5 stream ones actual=%0d expected=4", ones);
        end

        cyc(0, 3'd0, 0, 0, 0, 0);
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule